// File: doc/BRIEF.md
# SIMT Warp Divergence Stack

This block keeps the active-lane mask of every warp in a SIMT core and handles branches where the lanes of one warp disagree. Divergence is tracked separately for each warp. A branch can split the enabled lanes of a warp. When that happens, the block saves two records on that warp's own stack: a rejoin record and a deferred-path record. It then enables only the lanes that took the branch. When the warp later arrives at the rejoin address, the block pops the deferred path and runs it with the other lanes. When the warp arrives at the rejoin address a second time, the block restores the mask the warp had before the branch. Lanes outside the current mask are disabled and must not commit results.

The fetch logic presents one step per cycle. A step names a warp and the address that warp has reached. If the instruction was a branch, the step also carries the resolved per-lane taken mask, the target address, the fall-through address and the rejoin address. One cycle later the block returns the address to fetch next and the mask to execute under. What the instructions do is outside this block.

Top module: `simt_div_stack`

## Requirements
- R1: After reset every warp has all lanes enabled, `out_valid` is 0 and `ovf_err` is 0. A non-branch step on a fresh warp returns the all-ones mask.
- R2: A branch in which every enabled lane is taken leaves the mask and the stack unchanged and returns `br_target_pc`.
- R3: A branch in which no enabled lane is taken leaves the mask and the stack unchanged and returns `br_fall_pc`.
- R4: A branch that splits the enabled lanes pushes two records and returns `br_target_pc`. The new mask is the set of enabled lanes whose `br_taken_mask` bit is 1; bit i of every mask is lane i.
- R5: A non-branch step whose `step_pc` equals the rejoin address of the warp's top record pops that record. The first pop after a split returns `br_fall_pc` with the enabled-but-not-taken lanes. The second pop returns the rejoin address with the pre-branch mask.
- R6: Bits of `br_taken_mask` for lanes that are currently disabled have no effect.
- R7: Each warp has its own mask and its own stack. A step on one warp does not change another warp.
- R8: A split that would push past DEPTH records pushes nothing and leaves the mask unchanged. It returns `br_target_pc` and sets `ovf_err`, which stays at 1 until reset.
- R9: A non-branch step that does not match the top rejoin address, or that comes when the stack is empty, returns `step_pc` and leaves the mask unchanged.
- R10: The outputs are registered. `out_valid` is 1 exactly one cycle after a step, and `out_warp` echoes that step's warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A step is presented this cycle |
| step_warp | input | WID_W | Warp index of the step |
| step_pc | input | PC_W | Address the warp has reached |
| br_valid | input | 1 | The step is a resolved branch |
| br_taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target_pc | input | PC_W | Branch target address |
| br_fall_pc | input | PC_W | Fall-through address |
| br_reconv_pc | input | PC_W | Address where both paths rejoin |
| out_valid | output | 1 | Result of the previous cycle's step |
| out_warp | output | WID_W | Warp of that result |
| out_pc | output | PC_W | Next address to fetch for that warp |
| out_mask | output | LANES | Lanes enabled for that warp |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
The bench runs one small configuration: 8 lanes, 2 warps and a stack of 4 records. On one warp it drives every possible taken mask, from a full mask, through the branch and through both pops.

A design that mixed up the two pushed records would return the rejoin address first. A design that popped on the wrong compare would never restore the full mask. Nested splits then fill the stack. They show whether a taken mask with disabled lanes set wrongly splits the warp. They also show whether an overflowing split corrupts the stack or the mask. A step on the other warp while the first is split shows whether state leaks between warps.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

   typedef enum logic [2:0] {
      ACT_PASS,
      ACT_TAKE_ALL,
      ACT_SKIP_ALL,
      ACT_SPLIT,
      ACT_REJOIN,
      ACT_SPILL
   } div_act_e;

endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split #(
   parameter int LANES = 32
) (
   input  logic [LANES-1:0] cur_mask,
   input  logic [LANES-1:0] br_mask,
   output logic [LANES-1:0] take_m,
   output logic [LANES-1:0] skip_m,
   output logic             none_take,
   output logic             all_take
);
   always_comb begin
      take_m    = cur_mask & br_mask;
      skip_m    = cur_mask & ~br_mask;
      none_take = (take_m == '0);
      all_take  = (skip_m == '0);
   end
endmodule

// File: rtl/simt_warp_ctx.sv
module simt_warp_ctx #(
   parameter  int LANES = 32,
   parameter  int PC_W  = 32,
   parameter  int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push2,
   input  logic             pop,
   input  logic             mask_we,
   input  logic [PC_W-1:0]  lo_rpc,
   input  logic [PC_W-1:0]  lo_pc,
   input  logic [LANES-1:0] lo_mask,
   input  logic [PC_W-1:0]  hi_rpc,
   input  logic [PC_W-1:0]  hi_pc,
   input  logic [LANES-1:0] hi_mask,
   input  logic [LANES-1:0] mask_d,
   output logic [PC_W-1:0]  top_rpc,
   output logic [PC_W-1:0]  top_pc,
   output logic [LANES-1:0] top_mask,
   output logic [LANES-1:0] cur_mask,
   output logic [CNT_W-1:0] depth,
   output logic             room2
);
   logic [PC_W-1:0]  rpc_q [DEPTH];
   logic [PC_W-1:0]  pc_q  [DEPTH];
   logic [LANES-1:0] msk_q [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic [LANES-1:0] mask_q;
   logic [CNT_W-1:0] top_c;
   logic [IDX_W-1:0] top_idx;

   // record storage: lower record first, deferred path on top
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push2 && (CNT_W'(i) == cnt_q)) begin
            rpc_q[i] <= lo_rpc;
            pc_q[i]  <= lo_pc;
            msk_q[i] <= lo_mask;
         end
         if (push2 && (CNT_W'(i) == cnt_q + CNT_W'(1))) begin
            rpc_q[i] <= hi_rpc;
            pc_q[i]  <= hi_pc;
            msk_q[i] <= hi_mask;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mask_q <= '1;
      end else begin
         if (push2)
            cnt_q <= cnt_q + CNT_W'(2);
         else if (pop && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
         if (mask_we)
            mask_q <= mask_d;
      end
   end

   always_comb begin
      top_c   = cnt_q - CNT_W'(1);
      top_idx = top_c[IDX_W-1:0];
      if (cnt_q == '0) begin
         top_rpc  = '0;
         top_pc   = '0;
         top_mask = '0;
      end else begin
         top_rpc  = rpc_q[top_idx];
         top_pc   = pc_q[top_idx];
         top_mask = msk_q[top_idx];
      end
      cur_mask = mask_q;
      depth    = cnt_q;
      room2    = (cnt_q <= CNT_W'(DEPTH - 2));
   end
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
   import simt_div_pkg::*;
#(
   parameter  int LANES = 32,
   parameter  int PC_W  = 32,
   parameter  int DEPTH = 8,
   parameter  int WARPS = 4,
   localparam int WID_W = (WARPS > 1) ? $clog2(WARPS) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_valid,
   input  logic [WID_W-1:0] step_warp,
   input  logic [PC_W-1:0]  step_pc,
   input  logic             br_valid,
   input  logic [LANES-1:0] br_taken_mask,
   input  logic [PC_W-1:0]  br_target_pc,
   input  logic [PC_W-1:0]  br_fall_pc,
   input  logic [PC_W-1:0]  br_reconv_pc,
   output logic             out_valid,
   output logic [WID_W-1:0] out_warp,
   output logic [PC_W-1:0]  out_pc,
   output logic [LANES-1:0] out_mask,
   output logic             ovf_err
);
   if (LANES < 2) begin : g_bad_lanes
      $error("simt_div_stack: LANES must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("simt_div_stack: DEPTH must be at least 2");
   end
   if (WARPS < 2 || (1 << WID_W) != WARPS) begin : g_bad_warps
      $error("simt_div_stack: WARPS must be a power of two, at least 2");
   end

   logic [LANES-1:0] cur_mask_w [WARPS];
   logic [LANES-1:0] top_mask_w [WARPS];
   logic [PC_W-1:0]  top_rpc_w  [WARPS];
   logic [PC_W-1:0]  top_pc_w   [WARPS];
   logic [CNT_W-1:0] depth_w    [WARPS];
   logic             room2_w    [WARPS];

   logic [LANES-1:0] sel_mask, sel_top_mask, take_m, skip_m, new_mask;
   logic [PC_W-1:0]  sel_top_rpc, sel_top_pc, new_pc;
   logic [CNT_W-1:0] sel_depth;
   logic             sel_room2, none_take, all_take;
   div_act_e         act;

   always_comb begin
      sel_mask     = cur_mask_w[step_warp];
      sel_top_mask = top_mask_w[step_warp];
      sel_top_rpc  = top_rpc_w[step_warp];
      sel_top_pc   = top_pc_w[step_warp];
      sel_depth    = depth_w[step_warp];
      sel_room2    = room2_w[step_warp];
   end

   simt_lane_split #(.LANES(LANES)) u_split (
      .cur_mask  (sel_mask),
      .br_mask   (br_taken_mask),
      .take_m    (take_m),
      .skip_m    (skip_m),
      .none_take (none_take),
      .all_take  (all_take)
   );

   always_comb begin
      if (br_valid) begin
         if (none_take)       act = ACT_SKIP_ALL;
         else if (all_take)   act = ACT_TAKE_ALL;
         else if (!sel_room2) act = ACT_SPILL;
         else                 act = ACT_SPLIT;
      end else if (sel_depth != '0 && step_pc == sel_top_rpc) begin
         act = ACT_REJOIN;
      end else begin
         act = ACT_PASS;
      end

      new_mask = sel_mask;
      new_pc   = step_pc;
      case (act)
         ACT_SKIP_ALL: new_pc = br_fall_pc;
         ACT_TAKE_ALL,
         ACT_SPILL:    new_pc = br_target_pc;
         ACT_SPLIT: begin
            new_pc   = br_target_pc;
            new_mask = take_m;
         end
         ACT_REJOIN: begin
            new_pc   = sel_top_pc;
            new_mask = sel_top_mask;
         end
         default: ;
      endcase
   end

   for (genvar w = 0; w < WARPS; w++) begin : g_warp
      logic hit;
      assign hit = step_valid && (step_warp == WID_W'(w));

      simt_warp_ctx #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_ctx (
         .clk      (clk),
         .rst_n    (rst_n),
         .push2    (hit && act == ACT_SPLIT),
         .pop      (hit && act == ACT_REJOIN),
         .mask_we  (hit && (act == ACT_SPLIT || act == ACT_REJOIN)),
         .lo_rpc   (br_reconv_pc),
         .lo_pc    (br_reconv_pc),
         .lo_mask  (sel_mask),
         .hi_rpc   (br_reconv_pc),
         .hi_pc    (br_fall_pc),
         .hi_mask  (skip_m),
         .mask_d   (new_mask),
         .top_rpc  (top_rpc_w[w]),
         .top_pc   (top_pc_w[w]),
         .top_mask (top_mask_w[w]),
         .cur_mask (cur_mask_w[w]),
         .depth    (depth_w[w]),
         .room2    (room2_w[w])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_warp  <= '0;
         out_pc    <= '0;
         out_mask  <= '0;
         ovf_err   <= 1'b0;
      end else begin
         out_valid <= step_valid;
         if (step_valid) begin
            out_warp <= step_warp;
            out_pc   <= new_pc;
            out_mask <= new_mask;
            if (act == ACT_SPILL)
               ovf_err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/simt_div_checks.sv
module simt_div_checks #(
   parameter int LANES = 32,
   parameter int PC_W  = 32,
   parameter int WID_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_valid,
   input logic [WID_W-1:0] step_warp,
   input logic             br_valid,
   input logic [LANES-1:0] br_taken_mask,
   input logic [PC_W-1:0]  br_target_pc,
   input logic [PC_W-1:0]  br_fall_pc,
   input logic             out_valid,
   input logic [WID_W-1:0] out_warp,
   input logic [PC_W-1:0]  out_pc,
   input logic [LANES-1:0] out_mask,
   input logic             ovf_err
);
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |=> out_valid);
   a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid |=> !out_valid);
   a_r10_warp_echo: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |=> out_warp == $past(step_warp));
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);
   a_r3_none_taken_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && br_valid && br_taken_mask == '0) |=> out_pc == $past(br_fall_pc));
   a_r2_all_taken_jumps: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && br_valid && br_taken_mask == '1) |=> out_pc == $past(br_target_pc));
   a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_mask != '0);
endmodule

bind simt_div_stack simt_div_checks #(.LANES(LANES), .PC_W(PC_W), .WID_W(WID_W)) u_div_checks (
   .clk           (clk),
   .rst_n         (rst_n),
   .step_valid    (step_valid),
   .step_warp     (step_warp),
   .br_valid      (br_valid),
   .br_taken_mask (br_taken_mask),
   .br_target_pc  (br_target_pc),
   .br_fall_pc    (br_fall_pc),
   .out_valid     (out_valid),
   .out_warp      (out_warp),
   .out_pc        (out_pc),
   .out_mask      (out_mask),
   .ovf_err       (ovf_err)
);

// File: tb/test_simt_div_stack.sv
module test_simt_div_stack;
   localparam int LANES = 8;
   localparam int PC_W  = 16;
   localparam int DEPTH = 4;
   localparam int WARPS = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             step_valid = 1'b0;
   logic [0:0]       step_warp = '0;
   logic [PC_W-1:0]  step_pc = '0;
   logic             br_valid = 1'b0;
   logic [LANES-1:0] br_taken_mask = '0;
   logic [PC_W-1:0]  br_target_pc = '0, br_fall_pc = '0, br_reconv_pc = '0;
   logic             out_valid, ovf_err;
   logic [0:0]       out_warp;
   logic [PC_W-1:0]  out_pc;
   logic [LANES-1:0] out_mask;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   simt_div_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .WARPS(WARPS)) i_simt_div_stack (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_warp(step_warp),
      .step_pc(step_pc), .br_valid(br_valid), .br_taken_mask(br_taken_mask),
      .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc), .br_reconv_pc(br_reconv_pc),
      .out_valid(out_valid), .out_warp(out_warp), .out_pc(out_pc), .out_mask(out_mask),
      .ovf_err(ovf_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic step(input int w, input logic [PC_W-1:0] pc, input logic br,
                       input logic [LANES-1:0] tk, input logic [PC_W-1:0] tg,
                       input logic [PC_W-1:0] fl, input logic [PC_W-1:0] rp);
      @(negedge clk);
      step_valid    = 1'b1;
      step_warp     = 1'(w);
      step_pc       = pc;
      br_valid      = br;
      br_taken_mask = tk;
      br_target_pc  = tg;
      br_fall_pc    = fl;
      br_reconv_pc  = rp;
      @(negedge clk);
      step_valid = 1'b0;
      br_valid   = 1'b0;
   endtask

   task automatic expect_out(input string tag, input int w, input logic [PC_W-1:0] pc,
                             input logic [LANES-1:0] m);
      chk({tag, " valid"}, 32'(out_valid), 32'd1);
      chk({tag, " warp"}, 32'(out_warp), 32'(w));
      chk({tag, " pc"}, 32'(out_pc), 32'(pc));
      chk({tag, " mask"}, 32'(out_mask), 32'(m));
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [LANES-1:0] tk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
      chk("R1 ovf_err after reset", 32'(ovf_err), 32'd0);
      step(0, 16'h0040, 1'b0, '0, '0, '0, '0);
      expect_out("R1 R9 fresh warp0", 0, 16'h0040, 8'hFF);
      step(1, 16'h0044, 1'b0, '0, '0, '0, '0);
      expect_out("R1 fresh warp1", 1, 16'h0044, 8'hFF);
      @(negedge clk);
      chk("R10 idle out_valid", 32'(out_valid), 32'd0);

      // exhaustive sweep over every taken mask from a full mask
      for (int t = 0; t < 256; t++) begin
         tk = 8'(t);
         step(0, 16'h0010, 1'b1, tk, 16'(16'h1000 + t), 16'(16'h2000 + t), 16'(16'h3000 + t));
         if (tk == 8'h00) begin
            expect_out("R3 uniform not-taken", 0, 16'(16'h2000 + t), 8'hFF);
         end else if (tk == 8'hFF) begin
            expect_out("R2 uniform taken", 0, 16'(16'h1000 + t), 8'hFF);
            step(0, 16'(16'h3000 + t), 1'b0, '0, '0, '0, '0);
            expect_out("R2 R9 no stack after uniform", 0, 16'(16'h3000 + t), 8'hFF);
         end else begin
            expect_out("R4 split", 0, 16'(16'h1000 + t), tk);
            if (t == 8'h5A) begin
               step(0, 16'h0777, 1'b0, '0, '0, '0, '0);
               expect_out("R9 no match keeps mask", 0, 16'h0777, tk);
            end
            step(0, 16'(16'h3000 + t), 1'b0, '0, '0, '0, '0);
            expect_out("R5 first pop", 0, 16'(16'h2000 + t), ~tk);
            step(0, 16'(16'h3000 + t), 1'b0, '0, '0, '0, '0);
            expect_out("R5 second pop", 0, 16'(16'h3000 + t), 8'hFF);
         end
      end

      // nested split, disabled-lane bits, overflow
      step(0, 16'h0100, 1'b1, 8'h0F, 16'h0200, 16'h0300, 16'h0400);
      expect_out("R4 outer split", 0, 16'h0200, 8'h0F);
      step(1, 16'h0500, 1'b0, '0, '0, '0, '0);
      expect_out("R7 warp1 untouched", 1, 16'h0500, 8'hFF);
      step(1, 16'h0504, 1'b1, 8'h0F, 16'h0600, 16'h0604, 16'h0608);
      expect_out("R7 warp1 own split", 1, 16'h0600, 8'h0F);
      step(1, 16'h0608, 1'b0, '0, '0, '0, '0);
      expect_out("R7 warp1 pop", 1, 16'h0604, 8'hF0);
      step(1, 16'h0608, 1'b0, '0, '0, '0, '0);
      expect_out("R7 warp1 rejoin", 1, 16'h0608, 8'hFF);
      step(0, 16'h0210, 1'b1, 8'hF0, 16'h0220, 16'h0230, 16'h0240);
      expect_out("R6 disabled lanes ignored", 0, 16'h0230, 8'h0F);
      step(0, 16'h0250, 1'b1, 8'hF3, 16'h0260, 16'h0270, 16'h0280);
      expect_out("R6 R4 inner split", 0, 16'h0260, 8'h03);
      chk("R8 no overflow yet", 32'(ovf_err), 32'd0);
      step(0, 16'h0264, 1'b1, 8'h01, 16'h0290, 16'h02A0, 16'h02B0);
      expect_out("R8 overflow keeps mask", 0, 16'h0290, 8'h03);
      chk("R8 overflow flag", 32'(ovf_err), 32'd1);
      step(0, 16'h0280, 1'b0, '0, '0, '0, '0);
      expect_out("R8 R5 inner pop intact", 0, 16'h0270, 8'h0C);
      step(0, 16'h0280, 1'b0, '0, '0, '0, '0);
      expect_out("R5 inner rejoin", 0, 16'h0280, 8'h0F);
      step(0, 16'h0400, 1'b0, '0, '0, '0, '0);
      expect_out("R5 outer pop", 0, 16'h0300, 8'hF0);
      step(0, 16'h0400, 1'b0, '0, '0, '0, '0);
      expect_out("R5 outer rejoin", 0, 16'h0400, 8'hFF);
      chk("R8 flag sticky", 32'(ovf_err), 32'd1);

      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 R8 flag cleared by reset", 32'(ovf_err), 32'd0);
      finish_run();
   end
endmodule